// File: doc/BRIEF.md
# Sequential Instruction Prefetch Engine

This block sits inside an instruction-cache controller and runs ahead of the fetch stream. Each time the front end presents a demand fetch, the engine walks a fixed number of consecutive cache lines beginning at the predicted next PC. It asks the cache whether each line is already present and checks its own prefetch queue. Lines found in neither place are queued. A line is 8 bytes and holds two 4-byte instructions, so the line address is the PC with its low three bits dropped.

Queued lines go to memory oldest first, and only in cycles where the front end is not making a demand fetch. Memory answers each request in the same cycle with a response tag. When line data later comes back carrying a tag that the queue holds, the engine writes that line into the instruction cache and frees the queue slot. A pipeline flush throws away queued lines that have not yet been sent. Lines already sent stay in the queue until their data arrives.

Top module: `ipf_engine`

## Requirements
- R1: Out of synchronous reset, `probe_valid_o`, `mem_req_valid_o` and `fill_valid_o` are all low, and the queue is empty.
- R2: A demand fetch sampled at a clock edge makes the engine probe lines `fetch_next_pc_i >> 3`, +1, … up to AHEAD (default 8) lines, one per cycle starting the next cycle. Each probed line that is neither cached nor queued is appended to the queue and later requested from memory.
- R3: A probed line for which `probe_hit_i` is high in its probe cycle is not queued.
- R4: A probed line equal to a line still held in the queue (unsent or awaiting data) is not queued again.
- R5: The queue holds DEPTH lines (default 32). When a probed line needs a slot and none is free, that line and the rest of its batch are dropped.
- R6: `mem_req_valid_o` is low in every cycle in which `fetch_valid_i` or `flush_i` is high. Otherwise it is high when an unsent line exists, and `mem_req_line_o` names the oldest unsent line.
- R7: A request answered with `mem_rsp_tag_i` equal to 0 is not accepted. The same line is presented again, still ahead of younger lines. A non-zero tag marks the line as sent with that tag.
- R8: When `mem_ret_valid_i` is high and `mem_ret_tag_i` equals the tag of a sent, queued line, then on the next cycle `fill_valid_o` is high with that line and the returned data, and the slot is freed. A return whose tag matches no queued line produces no fill.
- R9: `flush_i` discards every unsent queued line and ends the current probe batch. Lines already sent are kept, and their data still produces fills.
- R10: A new demand fetch during a batch restarts probing at the new line. The line probed in that same cycle is still handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Demand fetch this cycle |
| fetch_next_pc_i | input | PC_W | Predicted next PC (byte address) |
| flush_i | input | 1 | Pipeline squash or redirect |
| probe_valid_o | output | 1 | Cache lookup of `probe_line_o` requested |
| probe_line_o | output | PC_W-3 | Line address being probed |
| probe_hit_i | input | 1 | Probed line is present in the cache (same cycle) |
| mem_req_valid_o | output | 1 | Prefetch request to memory |
| mem_req_line_o | output | PC_W-3 | Line address requested |
| mem_rsp_tag_i | input | TAG_W | Same-cycle response tag, 0 = not accepted |
| mem_ret_valid_i | input | 1 | Memory returns line data |
| mem_ret_tag_i | input | TAG_W | Tag of returned data |
| mem_ret_data_i | input | DATA_W | Returned line data |
| fill_valid_o | output | 1 | Write a line into the cache |
| fill_line_o | output | PC_W-3 | Line address to write |
| fill_data_o | output | DATA_W | Line data to write |

## Verification
The checker holds several properties on every cycle:
- Requests never go out while a demand fetch or flush is present, and none go out in the cycle after a flush.
- Probing starts at the fetched line and steps by one line per cycle.
- A rejected request is presented again with the same line.
- Fills only follow a return.
- Sent-but-unfilled lines never exceed the queue depth.

Other behaviours are only visible across scenarios, so the directed tests check them:
- filtering of cached and duplicate lines
- oldest-first ordering
- dropping the tail of a batch when full
- survival of sent lines across a flush
- tag-matched fills in any return order

// File: rtl/ipf_pkg.sv
package ipf_pkg;

  // What happens to the line probed in a given cycle
  typedef enum logic [1:0] {
    CAND_NONE = 2'd0,  // nothing probed
    CAND_SKIP = 2'd1,  // cached or already queued
    CAND_PUSH = 2'd2,  // appended to the queue
    CAND_DROP = 2'd3   // no room: batch ends here
  } cand_act_e;

endpackage

// File: rtl/ipf_cand_gen.sv
module ipf_cand_gen #(
  parameter int LINE_W = 29,
  parameter int AHEAD  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic              abort_i,
  input  logic              stop_i,
  output logic              probe_valid_o,
  output logic [LINE_W-1:0] probe_line_o
);

  localparam int CNT_W = $clog2(AHEAD + 1);

  logic              act_q;
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      line_q <= '0;
      left_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      line_q <= start_line_i;
      left_q <= CNT_W'(AHEAD);
    end else if (abort_i || stop_i) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      line_q <= line_q + 1'b1;
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) act_q <= 1'b0;
    end
  end

  assign probe_valid_o = act_q;
  assign probe_line_o  = line_q;

endmodule

// File: rtl/ipf_ret_match.sv
module ipf_ret_match #(
  parameter int DEPTH = 32,
  parameter int TAG_W = 6
) (
  input  logic [DEPTH-1:0]         cand_i,
  input  logic [TAG_W-1:0]         tag_i [DEPTH],
  input  logic                     ret_valid_i,
  input  logic [TAG_W-1:0]         ret_tag_i,
  output logic                     hit_o,
  output logic [$clog2(DEPTH)-1:0] idx_o
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = ret_valid_i && cand_i[i] && (tag_i[i] == ret_tag_i);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = PTR_W'(i);
      end
    end
  end

endmodule

// File: rtl/ipf_pf_queue.sv
module ipf_pf_queue #(
  parameter int LINE_W = 29,
  parameter int DEPTH  = 32,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lookup_line_i,
  output logic              lookup_hit_o,
  output logic              full_o,
  input  logic              push_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic              flush_i,
  input  logic              send_block_i,
  output logic              req_valid_o,
  output logic [LINE_W-1:0] req_line_o,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic              ret_valid_i,
  input  logic [TAG_W-1:0]  ret_tag_i,
  input  logic [DATA_W-1:0] ret_data_i,
  output logic              fill_valid_o,
  output logic [LINE_W-1:0] fill_line_o,
  output logic [DATA_W-1:0] fill_data_o
);

  localparam int PTR_W = $clog2(DEPTH);

  // Ring order: head (oldest held) .. snd (oldest unsent) .. tail (next free)
  logic [PTR_W:0]      head_q, snd_q, tail_q;
  logic [PTR_W:0]      span;
  logic [DEPTH-1:0]    vld_q, sent_q;
  logic [LINE_W-1:0]   line_q [DEPTH];
  logic [TAG_W-1:0]    tag_q  [DEPTH];
  logic [DEPTH-1:0]    cam_hit;
  logic                pending, accept, do_push, head_adv;
  logic                ret_hit;
  logic [PTR_W-1:0]    ret_idx;
  logic [PTR_W-1:0]    tail_ix, snd_ix, head_ix;

  assign tail_ix = tail_q[PTR_W-1:0];
  assign snd_ix  = snd_q[PTR_W-1:0];
  assign head_ix = head_q[PTR_W-1:0];

  assign span   = tail_q - head_q;
  assign full_o = span[PTR_W];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cam
    assign cam_hit[i] = vld_q[i] && (line_q[i] == lookup_line_i);
  end
  assign lookup_hit_o = |cam_hit;

  assign pending     = (snd_q != tail_q);
  assign req_valid_o = pending && !send_block_i && !flush_i;
  assign req_line_o  = line_q[snd_ix];
  assign accept      = req_valid_o && (rsp_tag_i != '0);
  assign do_push     = push_i && !full_o && !flush_i;
  assign head_adv    = (head_q != tail_q) && !vld_q[head_ix];

  ipf_ret_match #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
  ) u_match (
    .cand_i      (vld_q & sent_q),
    .tag_i       (tag_q),
    .ret_valid_i (ret_valid_i),
    .ret_tag_i   (ret_tag_i),
    .hit_o       (ret_hit),
    .idx_o       (ret_idx)
  );

  // Payload storage: plain indexed writes, no reset
  always_ff @(posedge clk) begin
    if (do_push) line_q[tail_ix] <= push_line_i;
    if (accept)  tag_q[snd_ix]   <= rsp_tag_i;
    if (ret_hit) begin
      fill_line_o <= line_q[ret_idx];
      fill_data_o <= ret_data_i;
    end
  end

  // Control state
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q       <= '0;
      snd_q        <= '0;
      tail_q       <= '0;
      vld_q        <= '0;
      sent_q       <= '0;
      fill_valid_o <= 1'b0;
    end else begin
      if (flush_i) begin
        vld_q  <= vld_q & sent_q;
        tail_q <= snd_q;
      end else if (do_push) begin
        vld_q[tail_ix]  <= 1'b1;
        sent_q[tail_ix] <= 1'b0;
        tail_q          <= tail_q + 1'b1;
      end
      if (accept) begin
        sent_q[snd_ix] <= 1'b1;
        snd_q          <= snd_q + 1'b1;
      end
      if (ret_hit) vld_q[ret_idx] <= 1'b0;
      if (head_adv) head_q <= head_q + 1'b1;
      fill_valid_o <= ret_hit;
    end
  end

endmodule

// File: rtl/ipf_engine.sv
module ipf_engine #(
  parameter int PC_W       = 32,
  parameter int LINE_BYTES = 8,
  parameter int DEPTH      = 32,
  parameter int AHEAD      = 8,
  parameter int TAG_W      = 6,
  parameter int DATA_W     = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 fetch_valid_i,
  input  logic [PC_W-1:0]                      fetch_next_pc_i,
  input  logic                                 flush_i,
  output logic                                 probe_valid_o,
  output logic [PC_W-$clog2(LINE_BYTES)-1:0]   probe_line_o,
  input  logic                                 probe_hit_i,
  output logic                                 mem_req_valid_o,
  output logic [PC_W-$clog2(LINE_BYTES)-1:0]   mem_req_line_o,
  input  logic [TAG_W-1:0]                     mem_rsp_tag_i,
  input  logic                                 mem_ret_valid_i,
  input  logic [TAG_W-1:0]                     mem_ret_tag_i,
  input  logic [DATA_W-1:0]                    mem_ret_data_i,
  output logic                                 fill_valid_o,
  output logic [PC_W-$clog2(LINE_BYTES)-1:0]   fill_line_o,
  output logic [DATA_W-1:0]                    fill_data_o
);
  import ipf_pkg::*;

  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = PC_W - OFS_W;

  logic [LINE_W-1:0] fetch_line;
  logic              in_queue, q_full;
  cand_act_e         act;

  assign fetch_line = fetch_next_pc_i[PC_W-1:OFS_W];

  always_comb begin
    if (!probe_valid_o)                act = CAND_NONE;
    else if (probe_hit_i || in_queue)  act = CAND_SKIP;
    else if (q_full)                   act = CAND_DROP;
    else                               act = CAND_PUSH;
  end

  ipf_cand_gen #(
    .LINE_W (LINE_W),
    .AHEAD  (AHEAD)
  ) u_gen (
    .clk           (clk),
    .rst           (rst),
    .start_i       (fetch_valid_i),
    .start_line_i  (fetch_line),
    .abort_i       (flush_i),
    .stop_i        (act == CAND_DROP),
    .probe_valid_o (probe_valid_o),
    .probe_line_o  (probe_line_o)
  );

  ipf_pf_queue #(
    .LINE_W (LINE_W),
    .DEPTH  (DEPTH),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_queue (
    .clk           (clk),
    .rst           (rst),
    .lookup_line_i (probe_line_o),
    .lookup_hit_o  (in_queue),
    .full_o        (q_full),
    .push_i        (act == CAND_PUSH),
    .push_line_i   (probe_line_o),
    .flush_i       (flush_i),
    .send_block_i  (fetch_valid_i),
    .req_valid_o   (mem_req_valid_o),
    .req_line_o    (mem_req_line_o),
    .rsp_tag_i     (mem_rsp_tag_i),
    .ret_valid_i   (mem_ret_valid_i),
    .ret_tag_i     (mem_ret_tag_i),
    .ret_data_i    (mem_ret_data_i),
    .fill_valid_o  (fill_valid_o),
    .fill_line_o   (fill_line_o),
    .fill_data_o   (fill_data_o)
  );

endmodule

// File: rtl/ipf_engine_chk.sv
module ipf_engine_chk #(
  parameter int PC_W       = 32,
  parameter int LINE_BYTES = 8,
  parameter int DEPTH      = 32,
  parameter int TAG_W      = 6
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               fetch_valid_i,
  input logic [PC_W-1:0]                    fetch_next_pc_i,
  input logic                               flush_i,
  input logic                               probe_valid_o,
  input logic [PC_W-$clog2(LINE_BYTES)-1:0] probe_line_o,
  input logic                               mem_req_valid_o,
  input logic [PC_W-$clog2(LINE_BYTES)-1:0] mem_req_line_o,
  input logic [TAG_W-1:0]                   mem_rsp_tag_i,
  input logic                               mem_ret_valid_i,
  input logic                               fill_valid_o
);

  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int OUT_W = $clog2(DEPTH + 1) + 1;

  logic [OUT_W-1:0] outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) outstanding_q <= '0;
    else outstanding_q <= outstanding_q
                          + OUT_W'(mem_req_valid_o && (mem_rsp_tag_i != '0))
                          - OUT_W'(fill_valid_o);
  end

  // R6: demand fetch and flush both hold off memory requests
  p_no_req_on_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_i || flush_i) |-> !mem_req_valid_o);

  // R9: nothing unsent survives a flush
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !mem_req_valid_o);

  // R10: probing restarts at the fetched line
  p_probe_start_r10: assert property (@(posedge clk) disable iff (rst)
    fetch_valid_i |=> (probe_valid_o &&
                       probe_line_o == $past(fetch_next_pc_i[PC_W-1:OFS_W])));

  // R2: consecutive lines, one per cycle
  p_probe_step_r2: assert property (@(posedge clk) disable iff (rst)
    (probe_valid_o && !fetch_valid_i && !flush_i) |=>
      (!probe_valid_o || probe_line_o == $past(probe_line_o) + 1'b1));

  // R7: rejected request retried with the same line
  p_reject_retry_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid_o && mem_rsp_tag_i == '0) |=>
      (fetch_valid_i || flush_i ||
       (mem_req_valid_o && mem_req_line_o == $past(mem_req_line_o))));

  // R8: a fill only follows a data return
  p_fill_needs_ret_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_ret_valid_i |=> !fill_valid_o);

  // R5: never more lines in flight than slots
  p_capacity_r5: assert property (@(posedge clk) disable iff (rst)
    outstanding_q <= OUT_W'(DEPTH));

endmodule

bind ipf_engine ipf_engine_chk #(
  .PC_W       (PC_W),
  .LINE_BYTES (LINE_BYTES),
  .DEPTH      (DEPTH),
  .TAG_W      (TAG_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .fetch_valid_i   (fetch_valid_i),
  .fetch_next_pc_i (fetch_next_pc_i),
  .flush_i         (flush_i),
  .probe_valid_o   (probe_valid_o),
  .probe_line_o    (probe_line_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_line_o  (mem_req_line_o),
  .mem_rsp_tag_i   (mem_rsp_tag_i),
  .mem_ret_valid_i (mem_ret_valid_i),
  .fill_valid_o    (fill_valid_o)
);

// File: tb/ipf_engine_tb.sv
`timescale 1ns/1ps
module ipf_engine_tb;

  localparam int PC_W = 32;
  localparam int LW   = 29;
  localparam int TW   = 6;
  localparam int DW   = 64;
  localparam int LOGN = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetch_valid_i = 1'b0;
  logic [PC_W-1:0] fetch_next_pc_i = '0;
  logic          flush_i = 1'b0;
  logic          probe_valid_o;
  logic [LW-1:0] probe_line_o;
  logic          probe_hit_i;
  logic          mem_req_valid_o;
  logic [LW-1:0] mem_req_line_o;
  logic [TW-1:0] mem_rsp_tag_i = '0;
  logic          mem_ret_valid_i = 1'b0;
  logic [TW-1:0] mem_ret_tag_i = '0;
  logic [DW-1:0] mem_ret_data_i = '0;
  logic          fill_valid_o;
  logic [LW-1:0] fill_line_o;
  logic [DW-1:0] fill_data_o;

  always #5 clk = ~clk;

  ipf_engine u_dut (
    .clk (clk), .rst (rst),
    .fetch_valid_i (fetch_valid_i), .fetch_next_pc_i (fetch_next_pc_i),
    .flush_i (flush_i),
    .probe_valid_o (probe_valid_o), .probe_line_o (probe_line_o),
    .probe_hit_i (probe_hit_i),
    .mem_req_valid_o (mem_req_valid_o), .mem_req_line_o (mem_req_line_o),
    .mem_rsp_tag_i (mem_rsp_tag_i),
    .mem_ret_valid_i (mem_ret_valid_i), .mem_ret_tag_i (mem_ret_tag_i),
    .mem_ret_data_i (mem_ret_data_i),
    .fill_valid_o (fill_valid_o), .fill_line_o (fill_line_o),
    .fill_data_o (fill_data_o)
  );

  // Cache model: up to two resident lines
  logic          hit_en = 1'b0;
  logic [LW-1:0] hit_a = '0, hit_b = '0;
  assign probe_hit_i = hit_en && (probe_line_o == hit_a || probe_line_o == hit_b);

  int checks = 0, fails = 0;
  int req_cnt = 0, ret_ptr = 0, fill_cnt = 0;
  int rej_cnt = 0, rej_bad = 0;
  logic [LW-1:0] req_line [LOGN];
  logic [TW-1:0] req_tag  [LOGN];
  logic [LW-1:0] fil_line [LOGN];
  logic [DW-1:0] fil_data [LOGN];
  logic          reject = 1'b0;
  logic          rej_chk_en = 1'b0;
  logic [LW-1:0] rej_exp = '0;
  logic [TW-1:0] ntag = TW'(1);

  function automatic logic [DW-1:0] dat_of(input logic [LW-1:0] l);
    return {35'd0, l} * 64'd3 + 64'h1234_0000_0000_0000;
  endfunction

  // Memory model and monitors, just after each falling edge
  always begin
    @(negedge clk);
    #1;
    if (fill_valid_o) begin
      fil_line[fill_cnt % LOGN] = fill_line_o;
      fil_data[fill_cnt % LOGN] = fill_data_o;
      fill_cnt++;
    end
    if (mem_req_valid_o) begin
      if (reject) begin
        mem_rsp_tag_i = '0;
        rej_cnt++;
        if (rej_chk_en && mem_req_line_o != rej_exp) rej_bad++;
      end else begin
        mem_rsp_tag_i = ntag;
        req_line[req_cnt % LOGN] = mem_req_line_o;
        req_tag[req_cnt % LOGN]  = ntag;
        req_cnt++;
        ntag = (ntag == TW'(63)) ? TW'(1) : ntag + 1'b1;
      end
    end else begin
      mem_rsp_tag_i = '0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic fetch(input logic [PC_W-1:0] pc);
    @(negedge clk);
    fetch_valid_i   = 1'b1;
    fetch_next_pc_i = pc;
    @(negedge clk);
    fetch_valid_i   = 1'b0;
  endtask

  task automatic expect_reqs(input int base, input logic [LW-1:0] first,
                             input int n, input string rq);
    chk(req_cnt - base == n, rq, "request count", req_cnt - base, n);
    for (int k = 0; k < n; k++)
      chk(req_line[(base + k) % LOGN] == first + LW'(k), rq, "request line order",
          req_line[(base + k) % LOGN], first + LW'(k));
  endtask

  task automatic ret_one(input int idx);
    @(negedge clk);
    mem_ret_valid_i = 1'b1;
    mem_ret_tag_i   = req_tag[idx % LOGN];
    mem_ret_data_i  = dat_of(req_line[idx % LOGN]);
    @(negedge clk);
    mem_ret_valid_i = 1'b0;
  endtask

  task automatic drain(input bit rev, input string rq);
    int n, base;
    n = req_cnt - ret_ptr;
    base = fill_cnt;
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = rev ? (req_cnt - 1 - k) : (ret_ptr + k);
      @(negedge clk);
      mem_ret_valid_i = 1'b1;
      mem_ret_tag_i   = req_tag[idx % LOGN];
      mem_ret_data_i  = dat_of(req_line[idx % LOGN]);
    end
    @(negedge clk);
    mem_ret_valid_i = 1'b0;
    wait_cyc(4);
    chk(fill_cnt - base == n, rq, "fill count", fill_cnt - base, n);
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = rev ? (req_cnt - 1 - k) : (ret_ptr + k);
      chk(fil_line[(base + k) % LOGN] == req_line[idx % LOGN], rq, "fill line",
          fil_line[(base + k) % LOGN], req_line[idx % LOGN]);
      chk(fil_data[(base + k) % LOGN] == dat_of(req_line[idx % LOGN]), rq, "fill data",
          fil_data[(base + k) % LOGN], dat_of(req_line[idx % LOGN]));
    end
    ret_ptr = req_cnt;
  endtask

  task automatic t_reset;
    wait_cyc(1);
    chk(probe_valid_o == 1'b0, "R1", "probe_valid after reset", probe_valid_o, 0);
    chk(mem_req_valid_o == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid_o, 0);
    chk(fill_valid_o == 1'b0, "R1", "fill_valid after reset", fill_valid_o, 0);
  endtask

  // R2 R8: mid-line PC, full batch, out-of-order returns
  task automatic t_basic;
    int base, fb;
    base = req_cnt;
    fetch(32'h0000_1004);
    wait_cyc(12);
    expect_reqs(base, LW'('h200), 8, "R2");
    fb = fill_cnt;
    @(negedge clk);
    mem_ret_valid_i = 1'b1;
    mem_ret_tag_i   = TW'(40);
    mem_ret_data_i  = '1;
    @(negedge clk);
    mem_ret_valid_i = 1'b0;
    wait_cyc(3);
    chk(fill_cnt == fb, "R8", "fill on unmatched tag", fill_cnt - fb, 0);
    drain(1'b1, "R8");
  endtask

  // R6 R4 R10: held demand blocks requests, repeated restarts add no duplicate
  task automatic t_hold;
    int base;
    base = req_cnt;
    @(negedge clk);
    fetch_valid_i   = 1'b1;
    fetch_next_pc_i = 32'h0000_2000;
    wait_cyc(6);
    chk(req_cnt == base, "R6", "requests during demand fetch", req_cnt - base, 0);
    @(negedge clk);
    fetch_valid_i = 1'b0;
    wait_cyc(12);
    expect_reqs(base, LW'('h400), 8, "R4");
    drain(1'b0, "R8");
  endtask

  // R3: cached lines skipped
  task automatic t_cached;
    int base;
    logic [LW-1:0] exp_l [6];
    base = req_cnt;
    hit_en = 1'b1;
    hit_a  = LW'('h602);
    hit_b  = LW'('h605);
    fetch(32'h0000_3000);
    wait_cyc(12);
    hit_en = 1'b0;
    exp_l = '{LW'('h600), LW'('h601), LW'('h603), LW'('h604), LW'('h606), LW'('h607)};
    chk(req_cnt - base == 6, "R3", "request count with hits", req_cnt - base, 6);
    for (int k = 0; k < 6; k++)
      chk(req_line[(base + k) % LOGN] == exp_l[k], "R3", "request line",
          req_line[(base + k) % LOGN], exp_l[k]);
    drain(1'b0, "R8");
  endtask

  // R7: zero tag is a refusal, head line retried, order kept
  task automatic t_reject;
    int base;
    base = req_cnt;
    reject = 1'b1;
    rej_chk_en = 1'b1;
    rej_exp = LW'('h800);
    rej_cnt = 0;
    rej_bad = 0;
    fetch(32'h0000_4000);
    wait_cyc(6);
    chk(rej_cnt > 2, "R7", "refused attempts", rej_cnt, 3);
    chk(rej_bad == 0, "R7", "refused attempts on wrong line", rej_bad, 0);
    chk(req_cnt == base, "R7", "accepted while refusing", req_cnt - base, 0);
    reject = 1'b0;
    rej_chk_en = 1'b0;
    wait_cyc(12);
    expect_reqs(base, LW'('h800), 8, "R7");
    drain(1'b0, "R8");
  endtask

  // R5: full queue drops the batch remainder
  task automatic t_full;
    int base;
    base = req_cnt;
    for (int b = 0; b < 4; b++) begin
      fetch(32'h0000_5000 + 32'(b) * 32'h40);
      wait_cyc(12);
    end
    chk(req_cnt - base == 32, "R5", "lines held at capacity", req_cnt - base, 32);
    base = req_cnt;
    fetch(32'h0000_5100);
    wait_cyc(12);
    chk(req_cnt == base, "R5", "requests when full", req_cnt - base, 0);
    ret_one(ret_ptr);
    ret_ptr++;
    wait_cyc(4);
    fetch(32'h0000_5200);
    wait_cyc(12);
    expect_reqs(base, LW'('hA40), 1, "R5");
    drain(1'b0, "R8");
  endtask

  // R9: flush drops unsent lines and the batch, keeps sent ones
  task automatic t_flush;
    int base;
    base = req_cnt;
    fetch(32'h0000_6000);
    wait_cyc(12);
    expect_reqs(base, LW'('hC00), 8, "R9");
    base = req_cnt;
    reject = 1'b1;
    fetch(32'h0000_6100);
    wait_cyc(2);
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    wait_cyc(10);
    reject = 1'b0;
    wait_cyc(12);
    chk(req_cnt == base, "R9", "requests after flush", req_cnt - base, 0);
    drain(1'b0, "R9");
    base = req_cnt;
    fetch(32'h0000_6100);
    wait_cyc(12);
    expect_reqs(base, LW'('hC20), 8, "R9");
    drain(1'b0, "R8");
  endtask

  // R10: back-to-back demand fetches
  task automatic t_restart;
    int base;
    base = req_cnt;
    @(negedge clk);
    fetch_valid_i   = 1'b1;
    fetch_next_pc_i = 32'h0000_7000;
    @(negedge clk);
    fetch_next_pc_i = 32'h0000_7800;
    @(negedge clk);
    fetch_valid_i   = 1'b0;
    wait_cyc(14);
    chk(req_cnt - base == 9, "R10", "request count", req_cnt - base, 9);
    chk(req_line[base % LOGN] == LW'('hE00), "R10", "first line",
        req_line[base % LOGN], LW'('hE00));
    expect_reqs(base + 1, LW'('hF00), 8, "R10");
    req_cnt = req_cnt;
    drain(1'b0, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_hold();
    t_cached();
    t_reject();
    t_full();
    t_flush();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule